// File: doc/BRIEF.md
# Runaway-Software Watchdog with Reset or NMI Action

This block guards a processor against software that has stopped making progress. Software configures a mode register and an interval-select register, then starts the watchdog by writing 1 to the run bit. After that, software must write the run bit again before the selected interval ends. Each such write clears the count. If no such write arrives in time, the block raises a one-cycle request. A configuration bit chosen before start decides whether that request goes to the system reset generator or to the non-maskable interrupt input.

The count is built from two parts. A free-running prescaler on the system clock produces a tick every 2^TICK_LOG clocks. A tick counter then compares against one of four terminal values. A restart clears only the tick counter and not the prescaler. For this reason the first timeout after a restart may arrive up to one prescaler period before the nominal interval. A HALT power-state input leaves counting unaffected. A STOP input freezes both the prescaler and the tick counter.

Top module: `runaway_wdt`

## Requirements
- R1: After a synchronous active-low reset, both registers read 0, both request outputs are 0, and the counter is stopped, so no request appears until the watchdog is started.
- R2: Mode register (address 0) layout: bit 7 is the run bit, bit 4 enables detection, and bit 3 selects the action (1 = reset request, 0 = NMI request). A read returns these three bits in place and 0 in every other bit. Writing 1 to bit 7 starts the watchdog.
- R3: Select register (address 1) bits [2:0] choose the interval. Codes 000, 010, 100 and 110 give 2^(TICK_LOG+CNT_BASE), 2^(TICK_LOG+CNT_BASE+2), 2^(TICK_LOG+CNT_BASE+4) and 2^(TICK_LOG+CNT_BASE+6) clocks; with the default parameters these are 2^11, 2^13, 2^15 and 2^17. A read returns the stored code in bits [2:0].
- R4: A write of a select code with bit 0 set is prohibited and ignored, and the previous code stays in force.
- R5: With P the selected interval and T = 2^TICK_LOG, the first request after a run write lands between P−T+1 and P clock edges after the write edge.
- R6: Writing 1 to the run bit while running clears the count, so the next request is timed from that write.
- R7: A timeout raises rst_req_o when the action bit is 1, or nmi_req_o when it is 0. The request is high for exactly one cycle, and the two outputs are never high together.
- R8: After a timeout the counter restarts from zero and keeps running, so later requests follow exactly P clocks apart.
- R9: Writing 0 to the run bit has no effect. Once started, only a system reset stops the watchdog.
- R10: While the run bit is 1, writes to the enable bit, the action bit and the select register are ignored.
- R11: With the enable bit 0, no request is ever raised, even after the run bit is set.
- R12: Asserting halt_i does not change the counting.
- R13: While stop_i is high, the prescaler and counter freeze. A STOP period of S clocks delays the pending request by exactly S clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write address: 0 mode, 1 interval select |
| wr_data | input | 8 | Write data |
| rd_addr | input | 1 | Read address: 0 mode, 1 interval select |
| rd_data | output | 8 | Combinational read data |
| halt_i | input | 1 | HALT power state (counting continues) |
| stop_i | input | 1 | STOP power state (counting frozen) |
| rst_req_o | output | 1 | One-cycle system reset request |
| nmi_req_o | output | 1 | One-cycle non-maskable interrupt request |

## Verification
The bench builds the block with TICK_LOG = 2 and CNT_BASE = 2. This gives a four-clock prescaler period and intervals of 16, 64, 256 and 1024 clocks, so every legal select code and several back-to-back timeouts fit in a short run. Because the prescaler period is only four clocks, the early-arrival window of the first timeout is narrow enough to check tightly. The later periodic timeouts can be checked to the exact cycle. STOP shifts and run-bit restarts show up as whole-window displacements that a missing freeze or a missed clear cannot hide.

// File: rtl/wdt_pkg.sv
// Package: shared constants, field positions and the mode-state type
// for the runaway-software watchdog. Assumes an 8-bit register bus.
package wdt_pkg;
    localparam int REG_W   = 8;
    localparam int SEL_W   = 3;
    localparam int RUN_POS = 7;
    localparam int EN_POS  = 4;
    localparam int ACT_POS = 3;

    localparam logic ADDR_MODE = 1'b0;
    localparam logic ADDR_SEL  = 1'b1;

    typedef struct packed {
        logic run;   // watchdog started
        logic en;    // detection enabled
        logic act;   // 1: reset request, 0: NMI request
    } mode_t;

    // Legal interval codes have bit 0 clear
    function automatic logic code_legal(input logic [SEL_W-1:0] c);
        return (c[0] == 1'b0);
    endfunction
endpackage

// File: rtl/wdt_regs.sv
// Register file: mode register and interval-select register.
// Assumes one write per cycle. Configuration is locked once run is set;
// run can only be cleared by reset. Produces a restart strobe on any
// write of 1 to the run bit.
module wdt_regs
    import wdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_addr,
    input  logic [REG_W-1:0] wr_data,
    input  logic             rd_addr,
    output logic [REG_W-1:0] rd_data,
    output mode_t            mode_o,
    output logic [1:0]       sel_idx_o,
    output logic             restart_o
);
    mode_t            mode_q;
    logic [SEL_W-1:0] code_q;
    logic             wr_mode;
    logic             wr_sel;
    logic             unused_wr_bits;

    assign wr_mode        = wr_en && (wr_addr == ADDR_MODE);
    assign wr_sel         = wr_en && (wr_addr == ADDR_SEL);
    assign unused_wr_bits = ^wr_data[6:5];

    // Mode register update: configuration while stopped, run is sticky
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else if (wr_mode) begin
            if (!mode_q.run) begin
                mode_q.en  <= wr_data[EN_POS];
                mode_q.act <= wr_data[ACT_POS];
            end
            if (wr_data[RUN_POS]) begin
                mode_q.run <= 1'b1;
            end
        end
    end

    // Interval-select register update: legal codes only, while stopped
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= '0;
        end else if (wr_sel && !mode_q.run && code_legal(wr_data[SEL_W-1:0])) begin
            code_q <= wr_data[SEL_W-1:0];
        end
    end

    // Read multiplexer
    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_MODE) begin
            rd_data[RUN_POS] = mode_q.run;
            rd_data[EN_POS]  = mode_q.en;
            rd_data[ACT_POS] = mode_q.act;
        end else begin
            rd_data[SEL_W-1:0] = code_q;
        end
    end

    assign mode_o    = mode_q;
    assign sel_idx_o = code_q[2:1];
    assign restart_o = wr_mode && wr_data[RUN_POS];

    a_r9_run_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q.run |=> mode_q.run);
    a_r10_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q.run |=> ($stable(mode_q.en) && $stable(mode_q.act) && $stable(code_q)));
    a_r4_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
        code_q[0] == 1'b0);
endmodule

// File: rtl/wdt_prescaler.sv
// Free-running prescaler: emits a one-cycle tick every 2**TICK_LOG clocks.
// Never cleared by a restart; frozen (tick suppressed) while stop is high.
// Assumes TICK_LOG >= 1.
module wdt_prescaler #(
    parameter int TICK_LOG = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                stop_i,
    output logic                tick_o,
    output logic [TICK_LOG-1:0] phase_o
);
    logic [TICK_LOG-1:0] phase_q;

    // Phase counter: advances every clock outside STOP
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (!stop_i) begin
            phase_q <= phase_q + 1'b1;
        end
    end

    assign tick_o  = (phase_q == '1) && !stop_i;
    assign phase_o = phase_q;

    a_r13_pre_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> $stable(phase_q));
endmodule

// File: rtl/wdt_counter.sv
// Tick counter with four terminal values selected by a 2-bit index
// (2**(CNT_BASE + 2*i) ticks). Clears on restart, which wins over a tick;
// wraps to zero on expiry and keeps running. Assumes the index is held
// constant while active.
module wdt_counter #(
    parameter int CNT_BASE = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       active_i,
    input  logic       clear_i,
    input  logic       tick_i,
    input  logic [1:0] sel_idx_i,
    output logic       expire_o
);
    localparam int CW = CNT_BASE + 6;

    logic [CW-1:0] term [4];
    logic [CW-1:0] cnt_q;
    logic          at_term;

    for (genvar g = 0; g < 4; g++) begin : g_term
        localparam int SH = CNT_BASE + 2 * g;
        localparam logic [CW-1:0] TV = CW'((64'd1 << SH) - 64'd1);
        assign term[g] = TV;
    end

    assign at_term  = (cnt_q == term[sel_idx_i]);
    assign expire_o = active_i && tick_i && !clear_i && at_term;

    // Count ticks; restart clears, expiry wraps to zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear_i) begin
            cnt_q <= '0;
        end else if (active_i && tick_i) begin
            cnt_q <= at_term ? '0 : cnt_q + 1'b1;
        end
    end

    a_r8_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        expire_o |=> (cnt_q == '0));
    a_r13_cnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !clear_i) |=> $stable(cnt_q));
    a_r6_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (cnt_q == '0));
endmodule

// File: rtl/runaway_wdt.sv
// Top: runaway-software watchdog. Connects registers, prescaler and tick
// counter; routes an expiry to a registered one-cycle reset or NMI request.
// Assumes clock gating for STOP is modelled by stop_i; halt_i is observed
// only to document that HALT does not affect counting.
module runaway_wdt
    import wdt_pkg::*;
#(
    parameter int TICK_LOG = 3,
    parameter int CNT_BASE = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_addr,
    input  logic [REG_W-1:0] wr_data,
    input  logic             rd_addr,
    output logic [REG_W-1:0] rd_data,
    input  logic             halt_i,
    input  logic             stop_i,
    output logic             rst_req_o,
    output logic             nmi_req_o
);
    mode_t               mode;
    logic [1:0]          sel_idx;
    logic                restart;
    logic                tick;
    logic [TICK_LOG-1:0] phase;
    logic                expire;
    logic                unused_halt;

    assign unused_halt = halt_i;

    wdt_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .mode_o    (mode),
        .sel_idx_o (sel_idx),
        .restart_o (restart)
    );

    wdt_prescaler #(.TICK_LOG(TICK_LOG)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .stop_i  (stop_i),
        .tick_o  (tick),
        .phase_o (phase)
    );

    wdt_counter #(.CNT_BASE(CNT_BASE)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .active_i  (mode.run && mode.en),
        .clear_i   (restart),
        .tick_i    (tick),
        .sel_idx_i (sel_idx),
        .expire_o  (expire)
    );

    // Request outputs: one-cycle pulse on the line picked by the action bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_req_o <= 1'b0;
            nmi_req_o <= 1'b0;
        end else begin
            rst_req_o <= expire && mode.act;
            nmi_req_o <= expire && !mode.act;
        end
    end

    a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rst_req_o, nmi_req_o}));
    a_r7_rst_single: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |=> !rst_req_o);
    a_r7_nmi_single: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_req_o |=> !nmi_req_o);
    a_r11_silent: assert property (@(posedge clk) disable iff (!rst_n)
        !mode.en |=> (!rst_req_o && !nmi_req_o));
    a_r12_halt_runs: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_i && !stop_i) |=> (phase != $past(phase)));
endmodule

// File: tb/runaway_wdt_tb_top.sv
module runaway_wdt_tb_top;
    localparam int TL = 2;
    localparam int CB = 2;
    localparam longint T = longint'(1) << TL;

    typedef struct {
        int     kind;    // 1 reset request, 0 NMI request
        longint lo;
        longint hi;
        longint period;
        string  tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_addr = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_addr = 1'b0;
    logic [7:0] rd_data;
    logic       halt_i = 1'b0;
    logic       stop_i = 1'b0;
    logic       rst_req_o;
    logic       nmi_req_o;

    int     n_chk = 0;
    int     n_bad = 0;
    int     hits = 0;
    longint cyc = 0;
    exp_t   q[$];

    runaway_wdt #(.TICK_LOG(TL), .CNT_BASE(CB)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .halt_i(halt_i), .stop_i(stop_i),
        .rst_req_o(rst_req_o), .nmi_req_o(nmi_req_o)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) cyc = 0;
        else        cyc = cyc + 1;
    end

    task automatic chk(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    // Monitor: pop expected requests and compare kind and arrival cycle
    always @(negedge clk) begin
        if (rst_n) begin
            if (rst_req_o || nmi_req_o) begin
                if (q.size() == 0) begin
                    n_chk++; n_bad++;
                    $display("FAIL R11 unexpected request at cycle %0d actual={%0b,%0b} expected=none",
                             cyc, rst_req_o, nmi_req_o);
                end else begin
                    exp_t it;
                    logic [1:0] a;
                    logic [1:0] e;
                    it = q.pop_front();
                    a = {rst_req_o, nmi_req_o};
                    e = (it.kind == 1) ? 2'b10 : 2'b01;
                    n_chk++;
                    if (a != e || cyc < it.lo || cyc > it.hi) begin
                        n_bad++;
                        $display("FAIL %s/R7 actual kind=%0b cycle=%0d expected kind=%0b window=%0d..%0d",
                                 it.tag, a, cyc, e, it.lo, it.hi);
                    end
                    hits++;
                    q.push_back('{kind: it.kind, lo: cyc + it.period, hi: cyc + it.period,
                                  period: it.period, tag: "R8"});
                end
            end else if (q.size() > 0 && cyc > q[0].hi) begin
                n_chk++; n_bad++;
                $display("FAIL %s missed request actual=none by %0d expected window=%0d..%0d",
                         q[0].tag, cyc, q[0].lo, q[0].hi);
                void'(q.pop_front());
            end
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0; halt_i = 1'b0; stop_i = 1'b0;
        q.delete();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        hits = 0;
    endtask

    task automatic wr(input logic a, input logic [7:0] d, output longint e);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        e = cyc;
    endtask

    task automatic rd(input logic a, output logic [7:0] v);
        @(negedge clk);
        rd_addr = a;
        #1 v = rd_data;
    endtask

    // Driver: push the expected first request after a run write
    task automatic expect_first(input int kind, input int k, input longint e, input string tag);
        longint p;
        p = longint'(1) << (TL + CB + 2 * k);
        q.push_back('{kind: kind, lo: e + p - T + 1, hi: e + p, period: p, tag: tag});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] v;
        longint e;
        int h0;

        // R1: reset state
        do_reset();
        rd(1'b0, v); chk("R1 mode", v, 0);
        rd(1'b1, v); chk("R1 sel", v, 0);
        chk("R1 requests", {rst_req_o, nmi_req_o}, 0);
        repeat (300) @(negedge clk);
        chk("R1 idle no request", hits, 0);

        // R3 / R4: select codes
        wr(1'b1, 8'h02, e); rd(1'b1, v); chk("R3 code 010", v, 2);
        wr(1'b1, 8'h03, e); rd(1'b1, v); chk("R4 code 011 ignored", v, 2);
        wr(1'b1, 8'h07, e); rd(1'b1, v); chk("R4 code 111 ignored", v, 2);
        wr(1'b1, 8'h04, e); rd(1'b1, v); chk("R3 code 100", v, 4);
        wr(1'b1, 8'h00, e); rd(1'b1, v); chk("R3 code 000", v, 0);

        // R2 / R5 / R7 / R8: reset action, shortest interval
        wr(1'b0, 8'h98, e);
        expect_first(1, 0, e, "R5");
        rd(1'b0, v); chk("R2 mode readback", v, 8'h98);
        repeat (60) @(negedge clk);
        chk("R8 repeated reset requests", (hits >= 3) ? 1 : 0, 1);
        // R9 / R10: ignored writes while running
        wr(1'b0, 8'h00, e); rd(1'b0, v); chk("R9 run not cleared", v, 8'h98);
        wr(1'b0, 8'h10, e); rd(1'b0, v); chk("R10 mode locked", v, 8'h98);
        wr(1'b1, 8'h06, e); rd(1'b1, v); chk("R10 sel locked", v, 0);
        h0 = hits;
        repeat (40) @(negedge clk);
        chk("R9 still running", (hits - h0 >= 2) ? 1 : 0, 1);

        // R6 / R12: restart with HALT asserted, NMI action, code 100
        do_reset();
        halt_i = 1'b1;
        wr(1'b1, 8'h04, e);
        wr(1'b0, 8'h90, e);
        expect_first(0, 2, e, "R5");
        repeat (100) @(negedge clk);
        wr(1'b0, 8'h80, e);
        q.delete();
        expect_first(0, 2, e, "R6");
        repeat (599) @(negedge clk);
        chk("R12 halt count of NMI requests", hits, 2);
        halt_i = 1'b0;

        // R13: STOP freezes counting
        do_reset();
        wr(1'b1, 8'h02, e);
        wr(1'b0, 8'h90, e);
        expect_first(0, 1, e, "R13");
        repeat (19) @(negedge clk);
        stop_i = 1'b1;
        repeat (37) @(negedge clk);
        stop_i = 1'b0;
        q[0].lo = q[0].lo + 37;
        q[0].hi = q[0].hi + 37;
        repeat (150) @(negedge clk);
        chk("R13 requests after stop", hits, 2);

        // R11: detection disabled
        do_reset();
        wr(1'b0, 8'h80, e);
        repeat (300) @(negedge clk);
        chk("R11 no request when disabled", hits, 0);
        rd(1'b0, v); chk("R11 mode readback", v, 8'h80);

        // R3: longest interval
        do_reset();
        wr(1'b1, 8'h06, e); rd(1'b1, v); chk("R3 code 110", v, 6);
        wr(1'b0, 8'h90, e);
        expect_first(0, 3, e, "R3");
        repeat (1099) @(negedge clk);
        chk("R3 one request in longest interval", hits, 1);

        summary();
        $finish;
    end
endmodule